// File: doc/BRIEF.md
# Key-Unlocked Serial Register Port

This block sits beside an asynchronous SRAM bus and watches the completed bus cycles, using the chip enable, output enable, write enable and the lowest data line. Normal traffic goes to memory untouched. A 64-bit key can be sent one bit per write cycle on the lowest data line. When the whole key has matched, the block takes over the next 64 counted bus cycles. During those cycles it moves 64 bits of clock-register data over the same data line, and it raises a memory-inhibit output.

A bus cycle is counted when CE returns high. The type of the cycle comes from the OE and WE levels that were sampled while CE was low. The last such sample also supplies the data bit. Every strobe arrives already synchronised to `clk`. On unlock, a snapshot of the register file is taken from the parallel input. Read cycles shift this snapshot out, least significant bit first. Write cycles shift new bits in, and the result is handed back as a single 64-bit load when the transfer ends. One bit of the snapshot decides whether the external reset pin may abort a transfer.

Top module: `keyed_serial_port`

## Requirements
- R1: After `rst_n` is released, `mem_block`, `dq0_oe` and `regs_load` are all 0.
- R2: The key is 64 bits long. It is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, with each byte sent least significant bit first on `dq0_i`, one bit per write cycle (CE low with WE low). `mem_block` rises in the clock cycle that follows the CE rise ending the 64th matching write.
- R3: A read cycle (CE and OE low, WE high) returns the key position to bit 0. A key that a read interrupts part-way does not unlock when its remaining bits are sent. A full key sent after the read does unlock.
- R4: A write whose bit differs from the expected key bit stops matching. Every later write is ignored until the next read cycle, after which a full key unlocks.
- R5: `mem_block` stays 0 for every cycle before unlock. It stays 1 across the whole transfer.
- R6: During a transfer, `dq0_oe` is 1 exactly while CE and OE are low with WE high. On the k-th counted transfer cycle (k from 0), `dq0_o` carries bit k of the snapshot that was taken from `regs_i` at unlock.
- R7: In a transfer that holds at least one write, `regs_load` pulses for one clock after the 64th counted cycle. In `regs_o`, bit k holds the data bit of the k-th cycle when that cycle was a write, and bit k of the snapshot when it was a read. `regs_o` changes only together with that pulse.
- R8: A transfer made only of reads produces no `regs_load` pulse.
- R9: If snapshot bit 28 is 0, a low `ext_rst_n` during a transfer ends the transfer with no load, and `mem_block` falls on the following clock. If snapshot bit 28 is 1, `ext_rst_n` has no effect.
- R10: A CE cycle with both OE and WE high is not counted, either toward the key or toward the 64 transfer cycles.
- R11: After the 64th transfer cycle, `mem_block` returns to 0, key matching restarts from bit 0, and a new full key unlocks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| dq0_i | input | 1 | Lowest bus data line, input side |
| ext_rst_n | input | 1 | External transfer-abort pin, active low |
| regs_i | input | 64 | Current clock-register contents, captured at unlock |
| dq0_o | output | 1 | Serial data driven onto the lowest data line |
| dq0_oe | output | 1 | Drive enable for `dq0_o` |
| mem_block | output | 1 | Inhibits memory access during a transfer |
| regs_o | output | 64 | Register image assembled by a write transfer |
| regs_load | output | 1 | One-clock strobe that applies `regs_o` |

## Verification
The checker watches several rules on every clock. The drive enable may only be high while the port is blocking memory. `mem_block` may only rise on the clock where a bus cycle ends. A load is always a single pulse, given as the transfer closes, and `regs_o` never moves without it. An abort always drops the port with no load. Other behaviours depend on whole bus-cycle histories, and only the bench scenarios can show them: the exact key bit order, the reset of the key position on a read, freezing after a mismatch, the skipping of neutral cycles, and the bit-by-bit serial order in both directions, including transfers that mix reads and writes.

// File: rtl/ksp_pkg.sv
package ksp_pkg;
  // key period: 32 bits, sent twice; byte 0 sits in the low byte
  localparam logic [31:0] KEY_WORD = 32'h5CA33AC5;

  function automatic logic key_bit(input int unsigned idx);
    return KEY_WORD[5'(idx % 32)];
  endfunction
endpackage

// File: rtl/ksp_cycle_detect.sv
module ksp_cycle_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic dq0_i,
  output logic done,
  output logic is_wr,
  output logic is_rd,
  output logic dbit
);
  logic ce_q;
  logic wr_l, rd_l, bit_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      wr_l  <= 1'b0;
      rd_l  <= 1'b0;
      bit_l <= 1'b0;
    end else begin
      ce_q <= ce_n;
      if (!ce_n) begin
        wr_l  <= !we_n;
        rd_l  <= we_n && !oe_n;
        bit_l <= dq0_i;
      end
    end
  end

  assign done  = !ce_q && ce_n;
  assign is_wr = wr_l;
  assign is_rd = rd_l;
  assign dbit  = bit_l;
endmodule

// File: rtl/ksp_key_match.sv
module ksp_key_match #(
  parameter int NBITS = 64,
  localparam int PW = $clog2(NBITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic done,
  input  logic is_wr,
  input  logic is_rd,
  input  logic dbit,
  output logic unlock
);
  import ksp_pkg::*;
  logic [PW-1:0] ptr;
  logic          frozen;
  logic          hit;

  assign hit    = !busy && done && is_wr && !is_rd && !frozen && (dbit == key_bit(int'(ptr)));
  assign unlock = hit && (ptr == PW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || busy) begin
      ptr    <= '0;
      frozen <= 1'b0;
    end else if (done) begin
      if (is_rd) begin
        ptr    <= '0;
        frozen <= 1'b0;
      end else if (is_wr && !frozen) begin
        if (hit) ptr    <= (ptr == PW'(NBITS - 1)) ? '0 : ptr + 1'b1;
        else     frozen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ksp_xfer.sv
module ksp_xfer #(
  parameter int NBITS = 64,
  parameter int MASK_BIT = 28,
  localparam int PW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unlock,
  input  logic             done,
  input  logic             is_wr,
  input  logic             is_rd,
  input  logic             dbit,
  input  logic             ext_rst_n,
  input  logic [NBITS-1:0] regs_i,
  output logic             busy,
  output logic             sbit,
  output logic             abort_ev,
  output logic             step,
  output logic [NBITS-1:0] regs_o,
  output logic             regs_load
);
  logic [NBITS-1:0] sh, sh_nx;
  logic [PW-1:0]    cnt;
  logic             wrote, mask;

  assign step     = busy && done && (is_wr || is_rd);
  assign abort_ev = busy && !ext_rst_n && !mask;
  assign sbit     = sh[0];
  assign sh_nx    = {(is_wr ? dbit : sh[0]), sh[NBITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sh        <= '0;
      cnt       <= '0;
      wrote     <= 1'b0;
      mask      <= 1'b0;
      regs_o    <= '0;
      regs_load <= 1'b0;
    end else begin
      regs_load <= 1'b0;
      if (abort_ev) begin
        busy <= 1'b0;
      end else if (unlock) begin
        busy  <= 1'b1;
        sh    <= regs_i;
        cnt   <= '0;
        wrote <= 1'b0;
        mask  <= regs_i[MASK_BIT];
      end else if (step) begin
        sh    <= sh_nx;
        cnt   <= cnt + 1'b1;
        wrote <= wrote | is_wr;
        if (cnt == PW'(NBITS - 1)) begin
          busy      <= 1'b0;
          regs_load <= wrote | is_wr;
          if (wrote | is_wr) regs_o <= sh_nx;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_serial_port.sv
module keyed_serial_port #(
  parameter int NBITS = 64,
  parameter int MASK_BIT = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             dq0_i,
  input  logic             ext_rst_n,
  input  logic [NBITS-1:0] regs_i,
  output logic             dq0_o,
  output logic             dq0_oe,
  output logic             mem_block,
  output logic [NBITS-1:0] regs_o,
  output logic             regs_load
);
  logic cyc_done, cyc_wr, cyc_rd, cyc_bit;
  logic unlock, busy, sbit, abort_ev, xfer_step;

  ksp_cycle_detect u_cyc (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq0_i(dq0_i), .done(cyc_done), .is_wr(cyc_wr), .is_rd(cyc_rd), .dbit(cyc_bit)
  );

  ksp_key_match #(.NBITS(NBITS)) u_key (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(cyc_done),
    .is_wr(cyc_wr), .is_rd(cyc_rd), .dbit(cyc_bit), .unlock(unlock)
  );

  ksp_xfer #(.NBITS(NBITS), .MASK_BIT(MASK_BIT)) u_xfer (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .done(cyc_done),
    .is_wr(cyc_wr), .is_rd(cyc_rd), .dbit(cyc_bit), .ext_rst_n(ext_rst_n),
    .regs_i(regs_i), .busy(busy), .sbit(sbit), .abort_ev(abort_ev),
    .step(xfer_step), .regs_o(regs_o), .regs_load(regs_load)
  );

  assign mem_block = busy;
  assign dq0_oe    = busy && !ce_n && !oe_n && we_n;
  assign dq0_o     = busy && sbit;
endmodule

// File: rtl/keyed_serial_port_chk.sv
module keyed_serial_port_chk #(
  parameter int NBITS = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             dq0_oe,
  input logic             mem_block,
  input logic             regs_load,
  input logic [NBITS-1:0] regs_o,
  input logic             abort_ev
);
  p_drive_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq0_oe |-> mem_block);

  p_unlock_on_ce_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_block) |-> ($past(ce_n) && !$past(ce_n, 2)));

  p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_load |=> !regs_load);

  p_load_at_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    regs_load |-> (!mem_block && $past(mem_block)));

  p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> regs_load);

  p_abort_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (!mem_block && !regs_load));
endmodule

bind keyed_serial_port keyed_serial_port_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .dq0_oe(dq0_oe),
  .mem_block(mem_block), .regs_load(regs_load), .regs_o(regs_o),
  .abort_ev(abort_ev)
);

// File: tb/keyed_serial_port_tb.sv
`timescale 1ns/1ps
module keyed_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq0_i = 1'b0, ext_rst_n = 1'b1;
  logic [63:0] regs_i = '0;
  logic dq0_o, dq0_oe, mem_block, regs_load;
  logic [63:0] regs_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  keyed_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq0_i(dq0_i), .ext_rst_n(ext_rst_n), .regs_i(regs_i), .dq0_o(dq0_o),
    .dq0_oe(dq0_oe), .mem_block(mem_block), .regs_o(regs_o), .regs_load(regs_load)
  );

  function automatic logic kb(input int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 write, 1 read, 2 neutral; returns drive seen while CE low
  task automatic bus(input int kind, input logic d, output logic ob, output logic oen);
    @(negedge clk);
    ce_n = 1'b0; dq0_i = d;
    oe_n = (kind == 1) ? 1'b0 : 1'b1;
    we_n = (kind == 0) ? 1'b0 : 1'b1;
    @(posedge clk); @(negedge clk);
    ob = dq0_o; oen = dq0_oe;
    @(posedge clk); @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic bus0(input int kind, input logic d);
    logic a, b;
    bus(kind, d, a, b);
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) bus0(0, kb(i));
  endtask

  task automatic drain_reads(input int n);
    for (int i = 0; i < n; i++) bus0(1, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ob, oen;
    logic [63:0] snap, exp;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 mem_block", 64'(mem_block), 64'd0);
    chk("R1 dq0_oe", 64'(dq0_oe), 64'd0);
    chk("R1 regs_load", 64'(regs_load), 64'd0);

    // random junk writes, then read, then the key
    for (int i = 0; i < 20; i++) bus0(0, 1'($urandom));
    bus0(1, 1'b0);
    snap = {$urandom, $urandom};
    snap[28] = 1'b1;
    regs_i = snap;
    send_key(0, 63);
    chk("R5 no block before unlock", 64'(mem_block), 64'd0);
    send_key(63, 64);
    chk("R2 unlock after key", 64'(mem_block), 64'd1);

    // read-only transfer
    for (int k = 0; k < 64; k++) begin
      bus(1, 1'b0, ob, oen);
      if (k == 0 || k == 37 || k == 63) begin
        chk("R6 dq0_oe on read", 64'(oen), 64'd1);
        chk("R5 block in transfer", 64'(mem_block || k == 63), 64'd1);
      end
      chk("R6 serial bit", 64'(ob), 64'(snap[k]));
    end
    chk("R8 no load on reads", 64'(regs_load), 64'd0);
    chk("R11 idle after transfer", 64'(mem_block), 64'd0);

    // mixed transfer with random data, several rounds
    for (int r = 0; r < 3; r++) begin
      snap = {$urandom, $urandom};
      snap[28] = 1'b1;
      regs_i = snap;
      bus0(1, 1'b0);
      send_key(0, 64);
      chk("R11 relock", 64'(mem_block), 64'd1);
      for (int k = 0; k < 64; k++) begin
        logic d;
        bit rd;
        d = 1'($urandom);
        rd = ($urandom % 5) == 0;
        bus(rd ? 1 : 0, d, ob, oen);
        exp[k] = rd ? snap[k] : d;
        if (!rd && k < 4) chk("R6 no drive on write", 64'(oen), 64'd0);
        if (rd) chk("R6 serial bit mixed", 64'(ob), 64'(snap[k]));
      end
      chk("R7 load pulse", 64'(regs_load), 64'd1);
      chk("R7 load data", regs_o, exp);
      @(posedge clk); #1;
      chk("R7 pulse one clock", 64'(regs_load), 64'd0);
    end

    // R3: read mid-key
    bus0(1, 1'b0);
    send_key(0, 30);
    bus0(1, 1'b0);
    send_key(30, 64);
    chk("R3 interrupted key stays locked", 64'(mem_block), 64'd0);
    bus0(1, 1'b0);
    send_key(0, 20);
    bus0(1, 1'b0);
    send_key(0, 64);
    chk("R3 key after read unlocks", 64'(mem_block), 64'd1);
    drain_reads(64);

    // R4: mismatch freezes
    bus0(1, 1'b0);
    send_key(0, 10);
    bus0(0, ~kb(10));
    send_key(10, 64);
    chk("R4 frozen after mismatch", 64'(mem_block), 64'd0);
    send_key(0, 64);
    chk("R4 still frozen without read", 64'(mem_block), 64'd0);
    bus0(1, 1'b0);
    send_key(0, 64);
    chk("R4 read clears freeze", 64'(mem_block), 64'd1);
    drain_reads(64);

    // R10: neutral cycles not counted
    bus0(1, 1'b0);
    for (int i = 0; i < 64; i++) begin
      if (i % 9 == 4) bus0(2, ~kb(i));
      bus0(0, kb(i));
    end
    chk("R10 key with neutral cycles", 64'(mem_block), 64'd1);
    for (int i = 0; i < 63; i++) begin
      if (i % 7 == 2) bus0(2, 1'b1);
      bus0(1, 1'b0);
    end
    bus0(2, 1'b0);
    chk("R10 neutral not counted in transfer", 64'(mem_block), 64'd1);
    bus0(1, 1'b0);
    chk("R10 transfer ends on 64th counted", 64'(mem_block), 64'd0);

    // R9: abort enabled
    snap = {$urandom, $urandom};
    snap[28] = 1'b0;
    regs_i = snap;
    bus0(1, 1'b0);
    send_key(0, 64);
    for (int i = 0; i < 10; i++) bus0(0, 1'b1);
    @(negedge clk); ext_rst_n = 1'b0;
    @(negedge clk); ext_rst_n = 1'b1;
    chk("R9 abort drops block", 64'(mem_block), 64'd0);
    chk("R9 abort no load", 64'(regs_load), 64'd0);
    for (int i = 0; i < 54; i++) bus0(0, 1'b1);
    chk("R9 no later load", 64'(regs_load), 64'd0);
    chk("R9 stays idle", 64'(mem_block), 64'd0);

    // R9: abort masked
    snap[28] = 1'b1;
    regs_i = snap;
    bus0(1, 1'b0);
    send_key(0, 64);
    for (int i = 0; i < 10; i++) bus0(0, 1'b0);
    @(negedge clk); ext_rst_n = 1'b0;
    @(negedge clk); ext_rst_n = 1'b1;
    chk("R9 masked pin ignored", 64'(mem_block), 64'd1);
    for (int i = 0; i < 54; i++) bus0(0, 1'b0);
    chk("R9 masked transfer loads", 64'(regs_load), 64'd1);
    chk("R9 masked data", regs_o, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule